// File: doc/BRIEF.md
# Streaming Log-Ratio Global Tone Mapper

This block converts a stream of high-dynamic-range pixels into 8-bit display codes. Each input beat carries an unsigned fixed-point logarithm of scene radiance. The block places that value linearly between the darkest and brightest log values of the scene, so the darkest maps to 0 and the brightest maps to 255. The result is rounded to the nearest code.

The scene bounds are never found by storing a frame. A compare-min and compare-max pair tracks the frame that is passing through. When the next frame starts, the pair's result is copied into a set of bound registers, and those registers map every pixel of that next frame. Until the first full frame has been measured, the bounds cover the whole input range. The quotient comes from a restoring divider with one stage per output bit. The divider accepts one pixel per clock, and a stall at the output holds the whole pipeline.

The stream uses valid/ready handshakes in the style of AXI4-Stream. A start-of-frame flag and an end-of-line flag travel alongside each pixel, on the input side and on the output side.

Top module: `log_ratio_tonemap`

## Requirements
- R1: With `out_ready_i` held high, the pipeline accepts one pixel per clock. A pixel accepted on a clock edge appears on the output after exactly 2 + OUT_W edges, counting the accepting edge as the first (10 with OUT_W = 8).
- R2: For a pixel x with lo < x < hi, the output is round(255·(x − lo)/(hi − lo)), with exact halves rounded up. Here lo and hi are the bounds in force for the pixel's frame.
- R3: A pixel at or below lo maps to 0. A pixel at or above hi maps to 255 (when hi > lo).
- R4: The bounds used for a frame are the minimum and maximum input values of the previous frame. They take effect on the beat flagged start-of-frame and do not change during the frame.
- R5: The running minimum and maximum restart from the start-of-frame pixel. Values from earlier frames do not reach later bounds.
- R6: Until one frame has been measured after reset, lo = 0 and hi = 2^PIX_W − 1. With PIX_W = OUT_W = 8, the first frame is passed through unchanged.
- R7: When hi equals lo, every pixel of the frame maps to 0.
- R8: The start-of-frame flag (`*_sof_*`) and end-of-line flag (`*_eol_*`) leave the block on the same beat as the pixel they entered with.
- R9: While `out_ready_i` is low and `out_valid_o` is high, the output beat holds steady and no input is accepted. `in_ready_o` is high whenever the output stage is empty or is being consumed. No beat is lost or duplicated.
- R10: After reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take an input beat |
| in_data_i | input | PIX_W | Fixed-point log radiance |
| in_sof_i | input | 1 | First pixel of a frame |
| in_eol_i | input | 1 | Last pixel of a line |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Sink takes the output beat |
| out_data_o | output | OUT_W | Display code |
| out_sof_o | output | 1 | First pixel of a frame, aligned |
| out_eol_o | output | 1 | Last pixel of a line, aligned |

## Verification
The bench builds the block with PIX_W = 8 and OUT_W = 8. With these values the full-range bounds of the first frame make the mapping an identity, so the expected codes for that frame, and for a frame spanning 0..255, are the inputs themselves. The same values make the hand-worked quotients for narrow bounds small enough to tabulate, including exact half-code rounding, clamping outside the bounds, and a flat frame that collapses the next frame to zero. An intermittent output stall runs during the table pass, so the stall and hold behaviour is exercised against the same vectors.

// File: rtl/tonemap_pkg.sv
package tonemap_pkg;
  typedef struct packed {
    logic vld;
    logic sof;
    logic eol;
  } side_t;
endpackage

// File: rtl/tm_bound_track.sv
module tm_bound_track #(
  parameter int PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             sof_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] lo_o,
  output logic [PIX_W-1:0] hi_o
);
  logic [PIX_W-1:0] run_lo_q, run_hi_q, lat_lo_q, lat_hi_q;
  logic             seen_q;
  logic             take;

  // new frame with a measured predecessor: switch bounds on this very beat
  assign take = acc_i && sof_i && seen_q;
  assign lo_o = take ? run_lo_q : lat_lo_q;
  assign hi_o = take ? run_hi_q : lat_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_lo_q <= '1;
      run_hi_q <= '0;
      lat_lo_q <= '0;
      lat_hi_q <= '1;
      seen_q   <= 1'b0;
    end else if (acc_i) begin
      if (sof_i) begin
        run_lo_q <= pix_i;
        run_hi_q <= pix_i;
        seen_q   <= 1'b1;
        if (seen_q) begin
          lat_lo_q <= run_lo_q;
          lat_hi_q <= run_hi_q;
        end
      end else begin
        if (pix_i < run_lo_q) run_lo_q <= pix_i;
        if (pix_i > run_hi_q) run_hi_q <= pix_i;
      end
    end
  end

  a_r4_bounds_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && sof_i) |=> ($stable(lat_lo_q) && $stable(lat_hi_q)));

  a_r4_bound_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_lo_q <= lat_hi_q);

  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && sof_i) |=> (run_lo_q == $past(pix_i) && run_hi_q == $past(pix_i)));
endmodule

// File: rtl/tm_norm.sv
module tm_norm
  import tonemap_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int OUT_W = 8,
  localparam int NW   = PIX_W + OUT_W + 2,
  localparam int DW   = PIX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] lo_i,
  input  logic [PIX_W-1:0] hi_i,
  input  side_t            side_i,
  output logic [NW-1:0]    n_o,
  output logic [DW-1:0]    d_o,
  output side_t            side_o
);
  localparam int            DMAX  = (1 << OUT_W) - 1;
  localparam logic [NW-1:0] SCALE = NW'(2 * DMAX);

  logic [PIX_W-1:0] den, num;
  logic [NW-1:0]    n_d;
  logic [DW-1:0]    d_d;

  always_comb begin
    den = hi_i - lo_i;
    if (pix_i <= lo_i)      num = '0;
    else if (pix_i >= hi_i) num = den;
    else                    num = pix_i - lo_i;
    // q = floor((2*DMAX*num + den) / (2*den)) gives round-half-up
    if (den == '0) begin
      n_d = '0;
      d_d = DW'(2);
    end else begin
      n_d = NW'(num) * SCALE + NW'(den);
      d_d = {den, 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_o    <= '0;
      d_o    <= '0;
      side_o <= '0;
    end else if (en_i) begin
      n_o    <= n_d;
      d_o    <= d_d;
      side_o <= side_i;
    end
  end
endmodule

// File: rtl/tm_div_pipe.sv
module tm_div_pipe
  import tonemap_pkg::*;
#(
  parameter int NW = 22,
  parameter int DW = 13,
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_i,
  input  logic [DW-1:0] d_i,
  input  side_t         side_i,
  output logic [QW-1:0] q_o,
  output side_t         side_o
);
  logic [NW-1:0] rem_q  [QW];
  logic [DW-1:0] dv_q   [QW];
  logic [QW-1:0] quo_q  [QW];
  side_t         side_q [QW];

  for (genvar i = 0; i < QW; i++) begin : g_st
    localparam int B = QW - 1 - i;
    logic [NW-1:0] r_in, sh;
    logic [DW-1:0] d_in;
    logic [QW-1:0] q_in;
    side_t         s_in;

    if (i == 0) begin : g_first
      assign r_in = n_i;
      assign d_in = d_i;
      assign q_in = '0;
      assign s_in = side_i;
    end else begin : g_next
      assign r_in = rem_q[i-1];
      assign d_in = dv_q[i-1];
      assign q_in = quo_q[i-1];
      assign s_in = side_q[i-1];
    end

    assign sh = NW'(d_in) << B;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rem_q[i]  <= '0;
        dv_q[i]   <= '0;
        quo_q[i]  <= '0;
        side_q[i] <= '0;
      end else if (en_i) begin
        dv_q[i]   <= d_in;
        side_q[i] <= s_in;
        if (r_in >= sh) begin
          rem_q[i] <= r_in - sh;
          quo_q[i] <= q_in | (QW'(1) << B);
        end else begin
          rem_q[i] <= r_in;
          quo_q[i] <= q_in;
        end
      end
    end
  end

  assign q_o    = quo_q[QW-1];
  assign side_o = side_q[QW-1];

  a_r2_rem_below_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_q[QW-1].vld |-> (rem_q[QW-1] < NW'(dv_q[QW-1])));
endmodule

// File: rtl/log_ratio_tonemap.sv
module log_ratio_tonemap
  import tonemap_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] in_data_i,
  input  logic             in_sof_i,
  input  logic             in_eol_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o,
  output logic             out_sof_o,
  output logic             out_eol_o
);
  localparam int NW = PIX_W + OUT_W + 2;
  localparam int DW = PIX_W + 1;

  logic             adv, acc;
  logic [PIX_W-1:0] lo_eff, hi_eff;
  logic [PIX_W-1:0] s0_pix, s0_lo, s0_hi;
  side_t            s0_side, s1_side, so_side;
  logic [NW-1:0]    s1_n;
  logic [DW-1:0]    s1_d;

  // global stall: every stage moves only when the output slot frees
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;
  assign acc        = in_valid_i && adv;

  tm_bound_track #(.PIX_W(PIX_W)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .sof_i  (in_sof_i),
    .pix_i  (in_data_i),
    .lo_o   (lo_eff),
    .hi_o   (hi_eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_pix  <= '0;
      s0_lo   <= '0;
      s0_hi   <= '0;
      s0_side <= '0;
    end else if (adv) begin
      s0_pix  <= in_data_i;
      s0_lo   <= lo_eff;
      s0_hi   <= hi_eff;
      s0_side <= '{vld: in_valid_i, sof: in_valid_i && in_sof_i, eol: in_valid_i && in_eol_i};
    end
  end

  tm_norm #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_norm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .pix_i  (s0_pix),
    .lo_i   (s0_lo),
    .hi_i   (s0_hi),
    .side_i (s0_side),
    .n_o    (s1_n),
    .d_o    (s1_d),
    .side_o (s1_side)
  );

  tm_div_pipe #(.NW(NW), .DW(DW), .QW(OUT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .n_i    (s1_n),
    .d_i    (s1_d),
    .side_i (s1_side),
    .q_o    (out_data_o),
    .side_o (so_side)
  );

  assign out_valid_o = so_side.vld;
  assign out_sof_o   = so_side.sof;
  assign out_eol_o   = so_side.eol;

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sof_o) && $stable(out_eol_o)));

  a_r8_markers_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sof_o || out_eol_o) |-> out_valid_o);
endmodule

// File: tb/tb_log_ratio_tonemap.sv
module tb_log_ratio_tonemap;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int OUT_W = 8;
  localparam int NVEC  = 40;
  localparam int LAT   = 2 + OUT_W;

  // {pixel, expected}; 5 frames of 2 lines x 4 pixels
  localparam logic [15:0] VEC [NVEC] = '{
    // frame A: full-range bounds, identity
    {8'd20, 8'd20}, {8'd40, 8'd40}, {8'd60, 8'd60}, {8'd80, 8'd80},
    {8'd100, 8'd100}, {8'd120, 8'd120}, {8'd140, 8'd140}, {8'd180, 8'd180},
    // frame B: bounds 20..180
    {8'd20, 8'd0}, {8'd180, 8'd255}, {8'd100, 8'd128}, {8'd60, 8'd64},
    {8'd10, 8'd0}, {8'd250, 8'd255}, {8'd21, 8'd2}, {8'd140, 8'd191},
    // frame C: bounds 10..250
    {8'd10, 8'd0}, {8'd250, 8'd255}, {8'd130, 8'd128}, {8'd70, 8'd64},
    {8'd11, 8'd1}, {8'd249, 8'd254}, {8'd0, 8'd0}, {8'd255, 8'd255},
    // frame D: bounds 0..255, flat content
    {8'd77, 8'd77}, {8'd77, 8'd77}, {8'd77, 8'd77}, {8'd77, 8'd77},
    {8'd77, 8'd77}, {8'd77, 8'd77}, {8'd77, 8'd77}, {8'd77, 8'd77},
    // frame E: bounds 77..77 -> all zero
    {8'd77, 8'd0}, {8'd0, 8'd0}, {8'd255, 8'd0}, {8'd100, 8'd0},
    {8'd77, 8'd0}, {8'd1, 8'd0}, {8'd254, 8'd0}, {8'd200, 8'd0}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [PIX_W-1:0] in_data_i = '0;
  logic             in_sof_i = 1'b0;
  logic             in_eol_i = 1'b0;
  logic             out_valid_o;
  logic             out_ready_i = 1'b1;
  logic [OUT_W-1:0] out_data_o;
  logic             out_sof_o;
  logic             out_eol_o;

  int n_run = 0;
  int n_fail = 0;
  int ngot = 0;
  int cyc = 0;
  logic stall_en = 1'b0;
  logic [OUT_W-1:0] got_pix [64];
  logic             got_sof [64];
  logic             got_eol [64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  log_ratio_tonemap #(.PIX_W(PIX_W), .OUT_W(OUT_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_sof_i(in_sof_i), .in_eol_i(in_eol_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_eol_o(out_eol_o)
  );

  // sink: ready drops every third cycle when stalling is on
  always @(posedge clk_i) begin
    #1;
    out_ready_i = !stall_en || (cyc % 3 != 0);
    cyc = cyc + 1;
  end

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i && ngot < 64) begin
      got_pix[ngot] = out_data_o;
      got_sof[ngot] = out_sof_o;
      got_eol[ngot] = out_eol_o;
      ngot = ngot + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [PIX_W-1:0] p, input logic s, input logic e);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_data_i  = p;
    in_sof_i   = s;
    in_eol_i   = e;
    while (!in_ready_o) @(negedge clk_i);
    @(posedge clk_i);
  endtask

  function automatic string tag(input int i);
    case (i / 8)
      0: return "R6 first frame full range";
      1: return "R2/R3 bounds 20..180";
      2: return "R3/R4 bounds 10..250";
      3: return "R4 bounds 0..255";
      default: return "R7/R5 flat bounds";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    int guard;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10: reset state
    check("R10 out_valid after reset", int'(out_valid_o), 0);
    check("R10 in_ready after reset", int'(in_ready_o), 1);

    // table pass with intermittent output stall (R9)
    stall_en = 1'b1;
    for (int i = 0; i < NVEC; i++)
      send(VEC[i][15:8], (i % 8) == 0, (i % 8) == 3 || (i % 8) == 7);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    guard = 0;
    while (ngot < NVEC && guard < 2000) begin
      @(negedge clk_i);
      guard++;
    end
    check("R9 beats delivered under stall", ngot, NVEC);
    for (int i = 0; i < NVEC; i++) begin
      check(tag(i), int'(got_pix[i]), int'(VEC[i][7:0]));
      check("R8 sof aligned", int'(got_sof[i]), int'((i % 8) == 0));
      check("R8 eol aligned", int'(got_eol[i]), int'((i % 8) == 3 || (i % 8) == 7));
    end

    // R1: latency of a single pixel, frame F uses bounds 0..255 from frame E
    stall_en = 1'b0;
    repeat (3) @(negedge clk_i);
    send(8'd123, 1'b1, 1'b1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    cnt = 1;
    while (!out_valid_o && cnt < 100) begin
      @(negedge clk_i);
      cnt++;
    end
    check("R1 latency", cnt, LAT);
    check("R4 value after flat frame", int'(out_data_o), 123);

    // R1: back-to-back throughput; frame G has bounds 123..123 -> zero (R7)
    repeat (LAT + 2) @(negedge clk_i);
    for (int k = 0; k < 4; k++) send(8'd50 + 8'(k * 40), k == 0, k == 3);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    guard = 0;
    while (!out_valid_o && guard < 100) begin
      @(negedge clk_i);
      guard++;
    end
    for (int k = 0; k < 4; k++) begin
      check("R1 consecutive output beats", int'(out_valid_o), 1);
      check("R7 zero-span frame", int'(out_data_o), 0);
      @(negedge clk_i);
    end
    check("R1 stream ends after last beat", int'(out_valid_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule